// File: doc/BRIEF.md
# Receive FIFO with Trigger and Character Timeout

This block is the receive-side character store of one serial channel. The receive shift register hands over each finished character, together with its error flags, through a write strobe. The host takes characters out through a holding-register read port whose output always shows the oldest stored character.

Around the store sit the signals that tell the host when to come and read. A data-ready bit shows that anything is stored. A threshold interrupt fires once enough characters have piled up. A timeout interrupt fires when a few characters sit below the threshold with no new arrivals and no reads.

The receiver supplies a pulse at the middle of each stop bit. A separate timing source supplies a character-time tick. A self-clearing flush request empties the store without touching the shift register. A sticky overrun flag records characters lost because the store was full.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset, count is 0 and data_ready, trig_irq, tout_irq, overrun and flush_busy are all 0.
- R2: Characters leave in arrival order. rd_data and rd_err show the oldest stored character and its 3 error flags, and a read strobe removes that character at the next clock edge.
- R3: A write strobe while 16 characters are stored, with no read in the same cycle, drops the character. The count stays 16 and overrun is set. overrun stays set until a status_rd strobe, and is 0 in the cycle after that strobe.
- R4: data_ready is 1 in the cycle after the first character is stored. It stays 1 until the read that empties the store.
- R5: trig_sel selects the threshold: 2'b00 = 1, 2'b01 = 4, 2'b10 = 8, 2'b11 = 14 characters. With irq_en set, trig_irq is 1 exactly while count is at or above the threshold. It drops as soon as a read takes the count below the threshold.
- R6: With irq_en set and the store not empty, tout_irq asserts in the cycle after the fourth char_tick pulse with no intervening restart. It is never 1 while the store is empty.
- R7: A stop_mid pulse or a read strobe restarts the timeout. tout_irq is 0 in the following cycle, and four further ticks are needed before it fires again.
- R8: A flush_req pulse sets flush_busy in the next cycle. One cycle later the count is 0 and flush_busy has returned to 0 by itself.
- R9: With irq_en clear, trig_irq and tout_irq both stay 0 whatever the count and tick history.
- R10: A read strobe while the store is empty has no effect: the count stays 0 and data_ready stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Character-complete strobe from the shift register |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error flags of the received character |
| rd_en | input | 1 | Host holding-register read strobe |
| rd_data | output | 8 | Oldest stored character |
| rd_err | output | 3 | Error flags of the oldest character |
| status_rd | input | 1 | Host status read strobe, clears overrun |
| flush_req | input | 1 | Request to empty the store |
| flush_busy | output | 1 | Flush pending, self-clearing |
| trig_sel | input | 2 | Threshold select |
| irq_en | input | 1 | Shared enable of both interrupts |
| stop_mid | input | 1 | Pulse at the middle of a received stop bit |
| char_tick | input | 1 | One pulse per character time |
| count | output | 5 | Number of stored characters |
| data_ready | output | 1 | At least one character stored |
| trig_irq | output | 1 | Threshold interrupt |
| tout_irq | output | 1 | Character-timeout interrupt |
| overrun | output | 1 | Sticky lost-character flag |

## Verification
The bench aims at each threshold edge, one character below and at the threshold, for all four encodings. A wrong decode or an off-by-one compare would show there as an interrupt one character early or late. It fills the store to 16 and writes once more. A design that wrapped its pointer would corrupt the oldest character, which the scoreboard sees when the store is drained. The timeout is counted tick by tick and restarted by both a stop-bit pulse and a read, and ticks are also sent into an empty store. A counter that ignored one restart source, or that ran while empty, would raise the timeout at the wrong tick.

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int DEPTH   = 16,
  parameter int W       = 8,
  parameter int EW      = 3,
  parameter int TOUT_CH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [W-1:0]                wr_data,
  input  logic [EW-1:0]               wr_err,
  input  logic                        rd_en,
  output logic [W-1:0]                rd_data,
  output logic [EW-1:0]               rd_err,
  input  logic                        status_rd,
  input  logic                        flush_req,
  output logic                        flush_busy,
  input  logic [1:0]                  trig_sel,
  input  logic                        irq_en,
  input  logic                        stop_mid,
  input  logic                        char_tick,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output logic                        data_ready,
  output logic                        trig_irq,
  output logic                        tout_irq,
  output logic                        overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = $clog2(TOUT_CH+1);

  logic [W+EW-1:0] mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [TW-1:0]   tcnt;
  logic [CW-1:0]   thr;
  logic            full, empty, do_wr, do_rd, restart;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_rd   = rd_en && !empty && !flush_busy;
  assign do_wr   = wr_en && !flush_busy && (!full || do_rd);
  assign restart = stop_mid || rd_en || empty || flush_busy;

  assign {rd_err, rd_data} = mem[rptr];
  assign data_ready        = !empty;

  always_comb begin
    case (trig_sel)
      2'b00:   thr = CW'(1);
      2'b01:   thr = CW'(4);
      2'b10:   thr = CW'(8);
      default: thr = CW'(DEPTH - 2);
    endcase
  end

  assign trig_irq = irq_en && (count >= thr);
  assign tout_irq = irq_en && !empty && (tcnt == TW'(TOUT_CH));

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= {wr_err, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      count      <= '0;
      flush_busy <= 1'b0;
    end else if (flush_busy) begin
      wptr       <= '0;
      rptr       <= '0;
      count      <= '0;
      flush_busy <= 1'b0;
    end else begin
      flush_busy <= flush_req;
      if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  tcnt <= '0;
    else if (restart)                            tcnt <= '0;
    else if (char_tick && tcnt != TW'(TOUT_CH))  tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      overrun <= 1'b0;
    else if (wr_en && full && !do_rd && !flush_busy) overrun <= 1'b1;
    else if (status_rd)                              overrun <= 1'b0;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !flush_busy) |=> (full && overrun)); // R3
  AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> (!flush_busy && empty)); // R8
  AST_READ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || stop_mid) |=> !tout_irq); // R7
  AST_GATED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !(trig_irq || tout_irq)); // R9
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> empty); // R10
endmodule

// File: tb/rx_trig_fifo_bench.sv
module rx_trig_fifo_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, rd_en = 0, status_rd = 0, flush_req = 0;
  logic       irq_en = 0, stop_mid = 0, char_tick = 0;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_err = '0;
  logic [1:0] trig_sel = 2'b11;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [4:0] count;
  logic       flush_busy, data_ready, trig_irq, tout_irq, overrun;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [10:0] expq[$];

  always #5 clk = ~clk;

  rx_trig_fifo u_rx_trig_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
    .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err), .status_rd(status_rd),
    .flush_req(flush_req), .flush_busy(flush_busy), .trig_sel(trig_sel),
    .irq_en(irq_en), .stop_mid(stop_mid), .char_tick(char_tick), .count(count),
    .data_ready(data_ready), .trig_irq(trig_irq), .tout_irq(tout_irq), .overrun(overrun));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0; status_rd = 0; flush_req = 0; stop_mid = 0; char_tick = 0;
  endtask

  task automatic put(input logic [7:0] d, input logic [2:0] e);
    wr_en = 1; wr_data = d; wr_err = e;
    if (expq.size() < 16) expq.push_back({e, d});
    step();
  endtask

  task automatic take();
    rd_en = 1;
    step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1;
      step();
    end
  endtask

  // monitor: compare the head the design presents against the scoreboard
  always @(negedge clk) begin
    if (rd_en && expq.size() > 0) begin
      chk("R2 order", int'({rd_err, rd_data}), int'(expq[0]));
      void'(expq.pop_front());
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    // R1
    chk("R1 count", count, 0); chk("R1 dr", data_ready, 0);
    chk("R1 trig", trig_irq, 0); chk("R1 tout", tout_irq, 0);
    chk("R1 ovr", overrun, 0); chk("R1 flush", flush_busy, 0);
    // R10
    take();
    chk("R10 count", count, 0); chk("R10 dr", data_ready, 0);
    // R4 / R5 threshold 1
    irq_en = 1; trig_sel = 2'b00;
    chk("R5 sel00 empty", trig_irq, 0);
    put(8'h11, 3'b001);
    chk("R4 dr set", data_ready, 1); chk("R5 sel00 at1", trig_irq, 1);
    take();
    chk("R5 sel00 below", trig_irq, 0); chk("R4 dr clr", data_ready, 0);
    // R5 threshold 4
    trig_sel = 2'b01;
    for (int i = 0; i < 3; i++) put(8'h20 + 8'(i), 3'(i));
    chk("R5 sel01 at3", trig_irq, 0);
    put(8'h23, 3'b100);
    chk("R5 sel01 at4", trig_irq, 1);
    take();
    chk("R5 sel01 drop", trig_irq, 0);
    // R5 threshold 8
    trig_sel = 2'b10;
    for (int i = 0; i < 4; i++) put(8'h30 + 8'(i), 3'b010);
    chk("R5 sel10 at7", trig_irq, 0);
    put(8'h34, 3'b000);
    chk("R5 sel10 at8", trig_irq, 1);
    // R9
    irq_en = 0; #1;
    chk("R9 trig gated", trig_irq, 0);
    irq_en = 1;
    // R5 threshold 14
    trig_sel = 2'b11; #1;
    chk("R5 sel11 at8", trig_irq, 0);
    for (int i = 0; i < 5; i++) put(8'h40 + 8'(i), 3'b011);
    chk("R5 sel11 at13", trig_irq, 0);
    put(8'h45, 3'b101);
    chk("R5 sel11 at14", trig_irq, 1);
    // R3 fill and overflow
    put(8'h46, 3'b110); put(8'h47, 3'b111);
    chk("R3 full", count, 16);
    put(8'hEE, 3'b111);
    chk("R3 dropped", count, 16); chk("R3 ovr set", overrun, 1);
    step();
    chk("R3 ovr sticky", overrun, 1);
    status_rd = 1; step();
    chk("R3 ovr clr", overrun, 0);
    // drain, R2 via monitor, R4 hold
    for (int i = 0; i < 15; i++) take();
    chk("R4 dr held", data_ready, 1);
    take();
    chk("R4 dr last", data_ready, 0); chk("R2 drained", count, 0);
    // R6 timeout
    put(8'h55, 3'b000);
    ticks(3);
    chk("R6 three ticks", tout_irq, 0);
    ticks(1);
    chk("R6 four ticks", tout_irq, 1);
    irq_en = 0; #1;
    chk("R9 tout gated", tout_irq, 0);
    irq_en = 1;
    // R7 stop-bit restart
    stop_mid = 1; step();
    chk("R7 stop restart", tout_irq, 0);
    ticks(3);
    chk("R7 stop three", tout_irq, 0);
    ticks(1);
    chk("R7 stop four", tout_irq, 1);
    // R7 read restart
    put(8'h56, 3'b001);
    ticks(4);
    chk("R6 refire", tout_irq, 1);
    take();
    chk("R7 read restart", tout_irq, 0);
    ticks(3);
    chk("R7 read three", tout_irq, 0);
    ticks(1);
    chk("R7 read four", tout_irq, 1);
    take();
    // R6 empty
    ticks(6);
    chk("R6 empty", tout_irq, 0);
    // R8 flush
    put(8'h61, 3'b000); put(8'h62, 3'b000); put(8'h63, 3'b000);
    flush_req = 1; step();
    chk("R8 busy", flush_busy, 1); chk("R8 count held", count, 3);
    step();
    chk("R8 busy clr", flush_busy, 0); chk("R8 count 0", count, 0);
    expq.delete();
    put(8'h70, 3'b010);
    take();
    chk("R8 after flush", count, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule